// File: doc/BRIEF.md
# Frame Receive Overflow Handler

This block sits between a bit-oriented frame receiver and a bounded receive FIFO. The receiver hands it one beat per cycle. A beat is either a data byte, with the first byte of a frame marked as start of frame, or an end-of-frame beat that carries the receiver's own status bits and no data byte. Data bytes go into the FIFO in the same cycle they are accepted, as long as the FIFO reports more free entries than the number kept in reserve.

When a byte arrives and the FIFO has no unreserved space, the byte is dropped and the frame is marked as damaged. The first loss in a frame raises a one-cycle interrupt. The frame is not aborted. Later bytes are stored again as soon as space returns. The end-of-frame beat appends a status word to the FIFO that records whether any byte of the frame was lost. The reserved entry means this status word can normally always be written. If the FIFO is completely full, the status word is held inside the block and input is stalled until it can be written.

Each FIFO word carries a tag bit in its top position: 0 for a data byte and 1 for a status word.

Top module: `rx_ovf_handler`

## Requirements
- R1: A data beat accepted while `fifo_free` > RSV (default 1) is written to the FIFO in the same cycle as `fifo_wr_data` = {1'b0, in_data}.
- R2: A data beat accepted while `fifo_free` <= RSV is discarded, and `fifo_wr_en` stays low in that cycle.
- R3: `ovf_irq` is high for exactly the one cycle after the first discarded byte of a frame. Further discarded bytes of the same frame raise no pulse.
- R4: After discards, a later byte of the same frame is stored normally as soon as `fifo_free` > RSV again.
- R5: An accepted end-of-frame beat with `fifo_free` >= 1 writes, in the same cycle, the word {1'b1, ovf, in_stat}. Here ovf (bit DW-1 of the status byte) is 1 if and only if any byte of that frame was discarded.
- R6: A data beat carrying `in_sof` starts a fresh overflow record. A frame with no discards ends with the status overflow bit at 0, even if the previous frame lost bytes.
- R7: An end-of-frame beat accepted while `fifo_free` = 0 is held inside the block. `in_ready` stays low and nothing is written until the first cycle with `fifo_free` >= 1. In that cycle the held status word is written unchanged, and `in_ready` returns high in the next cycle.
- R8: During reset `fifo_wr_en` and `ovf_irq` are low and `in_ready` is high.
- R9: A cycle with `in_valid` low and no held status writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Beat from the receiver is present |
| in_sof | input | 1 | Beat is the first data byte of a frame |
| in_eof | input | 1 | Beat is the end-of-frame beat (no data byte) |
| in_data | input | DW | Received data byte |
| in_stat | input | DW-1 | Receiver status bits, valid with `in_eof` |
| in_ready | output | 1 | Block can accept a beat |
| fifo_free | input | CNT_W | Free entries currently in the FIFO |
| fifo_wr_en | output | 1 | Write strobe to the FIFO |
| fifo_wr_data | output | DW+1 | Tag bit (top) and byte to write |
| ovf_irq | output | 1 | Receive overflow interrupt pulse |

## Verification
Write strobes, written words and `in_ready` react to the current beat and to `fifo_free` within the same cycle. The bench therefore drives each beat just after a falling edge and compares these outputs one nanosecond later, before the next rising edge. The interrupt is a registered result and is due one cycle after the dropping beat. The reference model keeps that expectation pending for one beat and compares it at the next beat's sample point. A held status word moves through the same model state, so its write is expected in the first beat whose free count reaches one, and the return of `in_ready` is expected in the beat after that.

// File: rtl/rx_ovf_pkg.sv
package rx_ovf_pkg;

  typedef enum logic {
    TAG_DATA = 1'b0,
    TAG_STAT = 1'b1
  } word_tag_e;

endpackage

// File: rtl/rx_ovf_gate.sv
module rx_ovf_gate #(
  parameter int CNT_W = 5,
  parameter int RSV   = 1
) (
  input  logic             byte_acc,
  input  logic             eof_acc,
  input  logic [CNT_W-1:0] fifo_free,
  output logic             byte_store,
  output logic             byte_drop,
  output logic             stat_room,
  output logic             eof_room
);

  function automatic logic data_fits(input logic [CNT_W-1:0] free);
    return int'(free) > RSV;
  endfunction

  function automatic logic stat_fits(input logic [CNT_W-1:0] free);
    return free != '0;
  endfunction

  always_comb begin
    byte_store = byte_acc &  data_fits(fifo_free);
    byte_drop  = byte_acc & ~data_fits(fifo_free);
    stat_room  = stat_fits(fifo_free);
    eof_room   = eof_acc & stat_fits(fifo_free);
  end

endmodule

// File: rtl/rx_ovf_track.sv
module rx_ovf_track (
  input  logic clk,
  input  logic rst_n,
  input  logic byte_acc,
  input  logic in_sof,
  input  logic byte_drop,
  output logic ovf_lat,
  output logic ovf_irq
);

  logic ovf_base;
  logic first_loss;

  always_comb begin
    ovf_base   = (byte_acc & in_sof) ? 1'b0 : ovf_lat;
    first_loss = byte_drop & ~ovf_base;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_lat <= 1'b0;
      ovf_irq <= 1'b0;
    end else begin
      if (byte_acc) ovf_lat <= ovf_base | byte_drop;
      ovf_irq <= first_loss;
    end
  end

endmodule

// File: rtl/rx_ovf_stat.sv
module rx_ovf_stat #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          eof_acc,
  input  logic          stat_room,
  input  logic [DW-1:0] new_word,
  output logic          stat_wr,
  output logic [DW-1:0] stat_word,
  output logic          stat_pend
);

  logic [DW-1:0] held_word;

  always_comb begin
    stat_wr   = (stat_pend | eof_acc) & stat_room;
    stat_word = stat_pend ? held_word : new_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_pend <= 1'b0;
      held_word <= '0;
    end else if (stat_pend) begin
      if (stat_room) stat_pend <= 1'b0;
    end else if (eof_acc && !stat_room) begin
      stat_pend <= 1'b1;
      held_word <= new_word;
    end
  end

endmodule

// File: rtl/rx_ovf_handler.sv
module rx_ovf_handler
  import rx_ovf_pkg::*;
#(
  parameter  int DW    = 8,
  parameter  int DEPTH = 16,
  parameter  int RSV   = 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic [DW-1:0]    in_data,
  input  logic [DW-2:0]    in_stat,
  output logic             in_ready,
  input  logic [CNT_W-1:0] fifo_free,
  output logic             fifo_wr_en,
  output logic [DW:0]      fifo_wr_data,
  output logic             ovf_irq
);

  logic          accept, byte_acc, eof_acc;
  logic          byte_store, byte_drop, stat_room, eof_room;
  logic          ovf_lat, stat_wr, stat_pend;
  logic [DW-1:0] new_word, stat_word;

  assign in_ready = ~stat_pend;
  assign accept   = in_valid & in_ready;
  assign byte_acc = accept & ~in_eof;
  assign eof_acc  = accept &  in_eof;
  assign new_word = {ovf_lat, in_stat};

  rx_ovf_gate #(.CNT_W(CNT_W), .RSV(RSV)) u_gate (
    .byte_acc  (byte_acc),
    .eof_acc   (eof_acc),
    .fifo_free (fifo_free),
    .byte_store(byte_store),
    .byte_drop (byte_drop),
    .stat_room (stat_room),
    .eof_room  (eof_room)
  );

  rx_ovf_track u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .byte_acc (byte_acc),
    .in_sof   (in_sof),
    .byte_drop(byte_drop),
    .ovf_lat  (ovf_lat),
    .ovf_irq  (ovf_irq)
  );

  rx_ovf_stat #(.DW(DW)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .eof_acc  (eof_acc),
    .stat_room(stat_room),
    .new_word (new_word),
    .stat_wr  (stat_wr),
    .stat_word(stat_word),
    .stat_pend(stat_pend)
  );

  always_comb begin
    fifo_wr_en   = byte_store | stat_wr;
    fifo_wr_data = stat_wr ? {TAG_STAT, stat_word} : {TAG_DATA, in_data};
  end

endmodule

// File: rtl/rx_ovf_handler_chk.sv
module rx_ovf_handler_chk #(
  parameter int DW    = 8,
  parameter int CNT_W = 5,
  parameter int RSV   = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_eof,
  input logic [DW-1:0]    in_data,
  input logic             in_ready,
  input logic [CNT_W-1:0] fifo_free,
  input logic             fifo_wr_en,
  input logic [DW:0]      fifo_wr_data,
  input logic             ovf_irq,
  input logic             byte_drop,
  input logic             eof_room
);

  a_r1_store_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_eof && int'(fifo_free) > RSV)
      |-> (fifo_wr_en && fifo_wr_data == {1'b0, in_data}));

  a_r2_drop_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_eof && int'(fifo_free) <= RSV) |-> !fifo_wr_en);

  a_r3_irq_after_drop: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |-> $past(byte_drop));

  a_r5_status_needs_room: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr_en && fifo_wr_data[DW]) |-> (fifo_free != '0));

  a_r5_eof_writes_status: assert property (@(posedge clk) disable iff (!rst_n)
    eof_room |-> (fifo_wr_en && fifo_wr_data[DW]));

  a_r7_stall_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> !(fifo_wr_en && !fifo_wr_data[DW]));

  a_r7_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && fifo_free == '0) |=> !in_ready);

endmodule

bind rx_ovf_handler rx_ovf_handler_chk #(.DW(DW), .CNT_W(CNT_W), .RSV(RSV)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_eof      (in_eof),
  .in_data     (in_data),
  .in_ready    (in_ready),
  .fifo_free   (fifo_free),
  .fifo_wr_en  (fifo_wr_en),
  .fifo_wr_data(fifo_wr_data),
  .ovf_irq     (ovf_irq),
  .byte_drop   (byte_drop),
  .eof_room    (eof_room)
);

// File: tb/rx_ovf_handler_bench.sv
`timescale 1ns/1ps
module rx_ovf_handler_bench;

  localparam int DW    = 8;
  localparam int DEPTH = 16;
  localparam int RSV   = 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [DW-1:0]    in_data = '0;
  logic [DW-2:0]    in_stat = '0;
  logic             in_ready;
  logic [CNT_W-1:0] fifo_free = '0;
  logic             fifo_wr_en;
  logic [DW:0]      fifo_wr_data;
  logic             ovf_irq;

  int n_run = 0;
  int n_fail = 0;

  // model state
  bit        m_ovf = 0;
  bit        m_pend = 0;
  bit [DW-1:0] m_word = '0;
  bit        m_irq = 0;

  always #2 clk = ~clk;

  rx_ovf_handler #(.DW(DW), .DEPTH(DEPTH), .RSV(RSV)) u_rx_ovf_handler (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .in_data(in_data), .in_stat(in_stat), .in_ready(in_ready),
    .fifo_free(fifo_free), .fifo_wr_en(fifo_wr_en), .fifo_wr_data(fifo_wr_data),
    .ovf_irq(ovf_irq)
  );

  task automatic check(string req, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic beat(string req, bit v, bit sof, bit eof, int d, int st, int free);
    bit exp_ready, exp_wr, acc, base;
    int exp_word;
    bit next_irq;
    @(negedge clk);
    in_valid  = v;  in_sof = sof;  in_eof = eof;
    in_data   = d[DW-1:0];
    in_stat   = st[DW-2:0];
    fifo_free = free[CNT_W-1:0];
    #1;
    exp_ready = !m_pend;
    exp_wr    = 0;
    exp_word  = 0;
    next_irq  = 0;
    acc       = v && exp_ready;
    if (m_pend) begin
      if (free >= 1) begin
        exp_wr = 1; exp_word = 256 + m_word; m_pend = 0;
      end
    end else if (acc && eof) begin
      if (free >= 1) begin
        exp_wr = 1; exp_word = 256 + (m_ovf ? 128 : 0) + (st % 128);
      end else begin
        m_pend = 1; m_word = (m_ovf ? 128 : 0) + (st % 128);
      end
    end else if (acc) begin
      base = sof ? 0 : m_ovf;
      if (free > RSV) begin
        exp_wr = 1; exp_word = d % 256;
      end else begin
        next_irq = !base;
        base = 1;
      end
      m_ovf = base;
    end
    check("R7", "in_ready", int'(in_ready), int'(exp_ready));
    check(req, "fifo_wr_en", int'(fifo_wr_en), int'(exp_wr));
    if (exp_wr) check(req, "fifo_wr_data", int'(fifo_wr_data), exp_word);
    check("R3", "ovf_irq", int'(ovf_irq), int'(m_irq));
    m_irq = next_irq;
  endtask

  initial begin
    fork
      begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R8", "reset wr_en", int'(fifo_wr_en), 0);
        check("R8", "reset ready", int'(in_ready), 1);
        check("R8", "reset irq", int'(ovf_irq), 0);
        rst_n = 1'b1;
        // frame A: plenty of room
        beat("R1", 1, 1, 0, 8'hA1, 0, 8);
        beat("R1", 1, 0, 0, 8'h5C, 0, 8);
        beat("R1", 1, 0, 0, 8'hFF, 0, 2);
        beat("R5", 1, 0, 1, 0, 7'h15, 8);
        beat("R9", 0, 0, 0, 8'h77, 0, 8);
        // frame B: losses then resume
        beat("R1", 1, 1, 0, 8'h10, 0, 8);
        beat("R2", 1, 0, 0, 8'h11, 0, 1);
        beat("R2", 1, 0, 0, 8'h12, 0, 0);
        beat("R2", 1, 0, 0, 8'h13, 0, 1);
        beat("R4", 1, 0, 0, 8'h14, 0, 2);
        beat("R4", 1, 0, 0, 8'h15, 0, 5);
        beat("R5", 1, 0, 1, 0, 7'h2A, 3);
        // frame C: clean after damaged frame
        beat("R6", 1, 1, 0, 8'h20, 0, 5);
        beat("R6", 1, 0, 0, 8'h21, 0, 5);
        beat("R6", 1, 0, 1, 0, 7'h7F, 5);
        // frame D: first byte lost, status held on full FIFO
        beat("R2", 1, 1, 0, 8'h30, 0, 1);
        beat("R4", 1, 0, 0, 8'h31, 0, 4);
        beat("R7", 1, 0, 1, 0, 7'h01, 0);
        beat("R7", 1, 1, 0, 8'h40, 0, 0);
        beat("R7", 1, 1, 0, 8'h40, 0, 0);
        beat("R7", 1, 1, 0, 8'h40, 0, 2);
        beat("R7", 1, 1, 0, 8'h40, 0, 2);
        // frame E continues: loss, status into reserved entry
        beat("R2", 1, 0, 0, 8'h41, 0, 0);
        beat("R5", 1, 0, 1, 0, 7'h33, 1);
        beat("R9", 0, 0, 0, 0, 0, 3);
        beat("R9", 0, 0, 0, 0, 0, 3);
      end
      begin
        repeat (5000) @(posedge clk);
        check("R8", "watchdog expired", 1, 0);
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule